// File: doc/BRIEF.md
# Macroblock Edge Scan Controller

This controller sequences the deblocking pass for one macroblock of a 22 by 18 macroblock picture. When it is started with a macroblock coordinate, it sorts the macroblock into one of four position classes. The class depends on whether a neighbour exists above and whether one exists to the left. The controller then reports how large a pixel window must be fetched into the local luma and chroma buffers, and waits until that fetch is complete.

After the fetch, it walks the internal block edges one line per request. The order is all luma vertical edges, then all luma horizontal edges, then the chroma vertical edges (first plane, then second plane), then the chroma horizontal edges in the same plane order. Each request carries a buffer row and column, the plane and the edge direction. Edges on the picture border are skipped.

A boundary strength is taken from the strength input only at the first line of every four-line luma segment. It is stored, and it is reused for the remaining lines of that segment and for the chroma lines that sit on the same segment. After the last request the controller asks for writeback, then pulses done.

Top module: `mb_edge_scan`

## Requirements
- R1: After reset, fetch_req, filt_req, wb_req and done are all low.
- R2: A start in idle with an in-range coordinate raises fetch_req from the next cycle until fetch_done is seen. mb_class is {row!=0, column!=0}, so 0 is top-left, 1 is the rest of the top row, 2 is the rest of the left column and 3 is every other macroblock.
- R3: The window rows are 16 luma (8 chroma) plus 4 luma (2 chroma) when a neighbour exists above. The window columns are 16 luma (8 chroma) plus 4 luma (2 chroma) when a neighbour exists to the left.
- R4: Requests come in this order: luma vertical, luma horizontal, U vertical, V vertical, U horizontal, V horizontal. Within each pass, edges go in increasing order and lines go from 0 upward. filt_plane is 0 for Y, 1 for U and 2 for V. filt_dir is 0 for a vertical edge and 1 for a horizontal edge.
- R5: Edge 0 of a vertical pass is skipped in column 0. Edge 0 of a horizontal pass is skipped in row 0.
- R6: For a vertical edge e and line l, row = offy + l and col = offx + 4e. For a horizontal edge the row and column swap roles. offx is 4 luma (2 chroma) when a left neighbour exists and 0 otherwise; offy works the same way for the neighbour above.
- R7: bs_req is high exactly on luma lines 0, 4, 8 and 12. On those lines filt_bs equals seg_bs. On the other three lines of a segment, filt_bs repeats the value taken at the segment start.
- R8: On chroma edge k, line l, filt_bs equals the strength stored for luma edge 2k, segment l/2, in the same direction.
- R9: While filter_ready is low, the pending request and its address, plane and direction stay unchanged.
- R10: After the last request is accepted, wb_req is high until wb_done. done then pulses for one cycle and the block returns to idle.
- R11: A start while busy, or with column >= 22 or row >= 18, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | begin a macroblock |
| mb_x | input | 5 | macroblock column |
| mb_y | input | 5 | macroblock row |
| fetch_done | input | 1 | window fetch complete |
| filter_ready | input | 1 | filter accepts the current request |
| wb_done | input | 1 | writeback complete |
| seg_bs | input | 3 | boundary strength for the current segment |
| fetch_req | output | 1 | fetch the neighbour window |
| mb_class | output | 2 | position class |
| luma_rows | output | 5 | luma window height |
| luma_cols | output | 5 | luma window width |
| chroma_rows | output | 5 | chroma window height per plane |
| chroma_cols | output | 5 | chroma window width per plane |
| filt_req | output | 1 | filter request valid |
| filt_plane | output | 2 | plane of the request |
| filt_dir | output | 1 | edge direction |
| filt_row | output | 5 | buffer row |
| filt_col | output | 5 | buffer column |
| bs_req | output | 1 | strength sampled on this line |
| filt_bs | output | 3 | strength for this line |
| wb_req | output | 1 | write buffers back |
| done | output | 1 | one-cycle completion pulse |

## Verification
The hardest case to reach is chroma strength reuse. It can only be checked after the matching luma segment has stored a value, and only when a border has removed edge 0. The bench drives a fresh random strength on every cycle, including stall cycles, and keeps its own table of the values taken at luma segment heads. It also runs the top-left, top-row, left-column and far-corner macroblocks so that each skip pattern meets the chroma lookup. Random stalls on filter_ready also exercise request holding at segment heads.

// File: rtl/mbes_pkg.sv
package mbes_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_LUMA_V, ST_LUMA_H, ST_CHR_V, ST_CHR_H, ST_WB, ST_DONE
   } scan_st_e;
   localparam logic [1:0] PL_Y = 2'd0;
   localparam logic [1:0] PL_U = 2'd1;
   localparam logic [1:0] PL_V = 2'd2;
endpackage

// File: rtl/mbes_classify.sv
module mbes_classify #(
   parameter int MB_COLS = 22,
   parameter int MB_ROWS = 18,
   parameter int XW = 5,
   parameter int YW = 5
) (
   input  logic [XW-1:0] mb_x,
   input  logic [YW-1:0] mb_y,
   output logic          in_range,
   output logic          has_left,
   output logic          has_top
);
   assign in_range = (int'(mb_x) < MB_COLS) && (int'(mb_y) < MB_ROWS);
   assign has_left = (mb_x != '0);
   assign has_top  = (mb_y != '0);
endmodule

// File: rtl/mbes_walk.sv
module mbes_walk #(
   parameter int LUMA = 16,
   parameter int SUB  = 4,
   localparam int CLINES  = LUMA / 2,
   localparam int EDGES_L = LUMA / SUB,
   localparam int EDGES_C = CLINES / SUB,
   localparam int LW = $clog2(LUMA),
   localparam int EW = $clog2(EDGES_L)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          adv,
   input  logic          is_chroma,
   input  logic          first_edge,
   output logic [EW-1:0] edge_idx,
   output logic [LW-1:0] line_idx,
   output logic          pv,
   output logic          last
);
   logic line_end, edge_end;
   logic [EW-1:0] edge_start;

   assign edge_start = first_edge ? EW'(1) : EW'(0);
   assign line_end = line_idx == LW'(is_chroma ? CLINES - 1 : LUMA - 1);
   assign edge_end = edge_idx == EW'(is_chroma ? EDGES_C - 1 : EDGES_L - 1);
   assign last     = line_end && edge_end && (!is_chroma || pv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_idx <= '0;
         line_idx <= '0;
         pv       <= 1'b0;
      end else if (init) begin
         edge_idx <= edge_start;
         line_idx <= '0;
         pv       <= 1'b0;
      end else if (adv) begin
         if (!line_end) begin
            line_idx <= line_idx + LW'(1);
         end else begin
            line_idx <= '0;
            if (!edge_end) begin
               edge_idx <= edge_idx + EW'(1);
            end else begin
               edge_idx <= edge_start;
               pv       <= 1'b1;
            end
         end
      end
   end

   // R5
   border_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && first_edge) |-> (edge_idx != '0));
endmodule

// File: rtl/mbes_bs_store.sv
module mbes_bs_store #(
   parameter int EDGES = 4,
   parameter int NSEG  = 4,
   parameter int BSW   = 3,
   localparam int EW = $clog2(EDGES),
   localparam int SW = $clog2(NSEG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic           wr_dir,
   input  logic [EW-1:0]  wr_edge,
   input  logic [SW-1:0]  wr_seg,
   input  logic [BSW-1:0] wr_bs,
   input  logic           rd_dir,
   input  logic [EW-1:0]  rd_edge,
   input  logic [SW-1:0]  rd_seg,
   output logic [BSW-1:0] rd_bs
);
   logic [1:0][BSW-1:0] rd_all;

   for (genvar d = 0; d < 2; d++) begin : g_dir
      logic [BSW-1:0] tab [EDGES*NSEG];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < EDGES*NSEG; i++) tab[i] <= '0;
         end else if (wr && (wr_dir == (d != 0))) begin
            tab[{wr_edge, wr_seg}] <= wr_bs;
         end
      end
      assign rd_all[d] = tab[{rd_edge, rd_seg}];
   end

   assign rd_bs = rd_all[rd_dir];
endmodule

// File: rtl/mb_edge_scan.sv
module mb_edge_scan import mbes_pkg::*; #(
   parameter int MB_COLS = 22,
   parameter int MB_ROWS = 18,
   parameter int LUMA    = 16,
   parameter int SUB     = 4,
   parameter int EXT     = 4,
   parameter int BSW     = 3,
   localparam int XW = $clog2(MB_COLS),
   localparam int YW = $clog2(MB_ROWS),
   localparam int AW = $clog2(LUMA + EXT),
   localparam int WW = $clog2(LUMA + EXT + 1),
   localparam int LW = $clog2(LUMA),
   localparam int EDGES_L = LUMA / SUB,
   localparam int EW = $clog2(EDGES_L)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [XW-1:0]  mb_x,
   input  logic [YW-1:0]  mb_y,
   input  logic           fetch_done,
   input  logic           filter_ready,
   input  logic           wb_done,
   input  logic [BSW-1:0] seg_bs,
   output logic           fetch_req,
   output logic [1:0]     mb_class,
   output logic [WW-1:0]  luma_rows,
   output logic [WW-1:0]  luma_cols,
   output logic [WW-1:0]  chroma_rows,
   output logic [WW-1:0]  chroma_cols,
   output logic           filt_req,
   output logic [1:0]     filt_plane,
   output logic           filt_dir,
   output logic [AW-1:0]  filt_row,
   output logic [AW-1:0]  filt_col,
   output logic           bs_req,
   output logic [BSW-1:0] filt_bs,
   output logic           wb_req,
   output logic           done
);
   initial begin : prm_chk
      assert (LUMA % SUB == 0 && (LUMA / 2) % SUB == 0) else $error("edge spacing must divide block size");
      assert (EXT % 2 == 0 && EXT <= SUB) else $error("neighbour margin must be even and within a sub-block");
   end

   scan_st_e st;
   logic in_rng, raw_left, raw_top, cls_left, cls_top;
   logic luma, chroma, adv, init, cur_h, nxt_h, first_cur, first_nxt, w_first;
   logic [EW-1:0] w_edge, rd_edge, rd_seg;
   logic [LW-1:0] w_line;
   logic w_pv, w_last;
   logic [AW-1:0] off_x, off_y, edge_pos, along;
   logic [BSW-1:0] rd_bs;

   mbes_classify #(.MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS), .XW(XW), .YW(YW)) u_cls (
      .mb_x(mb_x), .mb_y(mb_y), .in_range(in_rng), .has_left(raw_left), .has_top(raw_top));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cls_left <= 1'b0;
         cls_top  <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE:   if (start && in_rng) begin
                          st       <= ST_FETCH;
                          cls_left <= raw_left;
                          cls_top  <= raw_top;
                       end
            ST_FETCH:  if (fetch_done) st <= ST_LUMA_V;
            ST_LUMA_V: if (adv && w_last) st <= ST_LUMA_H;
            ST_LUMA_H: if (adv && w_last) st <= ST_CHR_V;
            ST_CHR_V:  if (adv && w_last) st <= ST_CHR_H;
            ST_CHR_H:  if (adv && w_last) st <= ST_WB;
            ST_WB:     if (wb_done) st <= ST_DONE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   assign luma      = (st == ST_LUMA_V) || (st == ST_LUMA_H);
   assign chroma    = (st == ST_CHR_V) || (st == ST_CHR_H);
   assign filt_req  = luma || chroma;
   assign adv       = filt_req && filter_ready;
   assign cur_h     = (st == ST_LUMA_H) || (st == ST_CHR_H);
   assign nxt_h     = (st == ST_LUMA_V) || (st == ST_CHR_V);
   assign first_cur = cur_h ? !cls_top : !cls_left;
   assign first_nxt = nxt_h ? !cls_top : !cls_left;
   assign init      = ((st == ST_FETCH) && fetch_done) || (adv && w_last);
   assign w_first   = init ? first_nxt : first_cur;

   mbes_walk #(.LUMA(LUMA), .SUB(SUB)) u_walk (
      .clk(clk), .rst_n(rst_n), .init(init), .adv(adv), .is_chroma(chroma),
      .first_edge(w_first), .edge_idx(w_edge), .line_idx(w_line), .pv(w_pv), .last(w_last));

   assign off_x    = cls_left ? AW'(chroma ? EXT / 2 : EXT) : '0;
   assign off_y    = cls_top  ? AW'(chroma ? EXT / 2 : EXT) : '0;
   assign edge_pos = AW'(int'(w_edge) * SUB);
   assign along    = AW'(w_line);
   assign filt_row = off_y + (cur_h ? edge_pos : along);
   assign filt_col = off_x + (cur_h ? along : edge_pos);
   assign filt_dir = cur_h;
   assign filt_plane = luma ? PL_Y : (w_pv ? PL_V : PL_U);

   assign bs_req  = luma && ((int'(w_line) % SUB) == 0);
   assign rd_edge = luma ? w_edge : EW'(int'(w_edge) * 2);
   assign rd_seg  = luma ? EW'(int'(w_line) / SUB) : EW'(int'(w_line) / (SUB / 2));

   mbes_bs_store #(.EDGES(EDGES_L), .NSEG(EDGES_L), .BSW(BSW)) u_bs (
      .clk(clk), .rst_n(rst_n), .wr(bs_req && filter_ready), .wr_dir(cur_h),
      .wr_edge(w_edge), .wr_seg(rd_seg), .wr_bs(seg_bs),
      .rd_dir(cur_h), .rd_edge(rd_edge), .rd_seg(rd_seg), .rd_bs(rd_bs));

   assign filt_bs = bs_req ? seg_bs : rd_bs;

   assign mb_class    = {cls_top, cls_left};
   assign luma_rows   = WW'(LUMA + (cls_top ? EXT : 0));
   assign luma_cols   = WW'(LUMA + (cls_left ? EXT : 0));
   assign chroma_rows = WW'(LUMA / 2 + (cls_top ? EXT / 2 : 0));
   assign chroma_cols = WW'(LUMA / 2 + (cls_left ? EXT / 2 : 0));
   assign fetch_req   = (st == ST_FETCH);
   assign wb_req      = (st == ST_WB);
   assign done        = (st == ST_DONE);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_req && !filter_ready) |=> (filt_req && $stable(filt_row) && $stable(filt_col)
                                        && $stable(filt_plane) && $stable(filt_dir)));
   // R6
   addr_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      filt_req |-> ((filt_plane == PL_Y) ? (filt_row < luma_rows && filt_col < luma_cols)
                                         : (filt_row < chroma_rows && filt_col < chroma_cols)));
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   wb_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wb_req) |-> $past(adv));
   // R11
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && start) |=> $stable(mb_class));
endmodule

// File: tb/mb_edge_scan_bench.sv
module mb_edge_scan_bench;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, start, fetch_done, filter_ready, wb_done;
   logic [4:0] mb_x, mb_y;
   logic [2:0] seg_bs;
   logic fetch_req, filt_req, filt_dir, bs_req, wb_req, done;
   logic [1:0] mb_class, filt_plane;
   logic [4:0] luma_rows, luma_cols, chroma_rows, chroma_cols, filt_row, filt_col;
   logic [2:0] filt_bs;

   int total = 0;
   int bad = 0;
   int tbl [2][4][4];

   mb_edge_scan u_mb_edge_scan (
      .clk(clk), .rst_n(rst_n), .start(start), .mb_x(mb_x), .mb_y(mb_y),
      .fetch_done(fetch_done), .filter_ready(filter_ready), .wb_done(wb_done), .seg_bs(seg_bs),
      .fetch_req(fetch_req), .mb_class(mb_class), .luma_rows(luma_rows), .luma_cols(luma_cols),
      .chroma_rows(chroma_rows), .chroma_cols(chroma_cols), .filt_req(filt_req),
      .filt_plane(filt_plane), .filt_dir(filt_dir), .filt_row(filt_row), .filt_col(filt_col),
      .bs_req(bs_req), .filt_bs(filt_bs), .wb_req(wb_req), .done(done));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int win(input int base, input int ext, input bit has);
      return base + (has ? ext : 0);
   endfunction

   task automatic run_mb(input int x, input int y);
      bit hl = (x != 0);
      bit ht = (y != 0);
      int ecls = (ht ? 2 : 0) + (hl ? 1 : 0);
      @(negedge clk); start = 1; mb_x = 5'(x); mb_y = 5'(y);
      @(negedge clk); start = 0; #1;
      chk("R2 fetch_req", int'(fetch_req), 1);
      chk("R2 class", int'(mb_class), ecls);
      chk("R3 luma_rows", int'(luma_rows), win(16, 4, ht));
      chk("R3 luma_cols", int'(luma_cols), win(16, 4, hl));
      chk("R3 chroma_rows", int'(chroma_rows), win(8, 2, ht));
      chk("R3 chroma_cols", int'(chroma_cols), win(8, 2, hl));
      // R11: start while busy
      @(negedge clk); start = 1; mb_x = 5'((x + 7) % 22); mb_y = 5'((y + 3) % 18);
      @(negedge clk); start = 0; #1;
      chk("R11 busy start class", int'(mb_class), ecls);
      chk("R2 fetch held", int'(fetch_req), 1);
      @(negedge clk); fetch_done = 1;
      @(negedge clk); fetch_done = 0;
      for (int ph = 0; ph < 6; ph++) begin
         bit ch = (ph >= 2);
         bit dir = (ph == 1 || ph == 4 || ph == 5);
         int pl = (ph < 2) ? 0 : ((ph == 2 || ph == 4) ? 1 : 2);
         int first = dir ? (ht ? 0 : 1) : (hl ? 0 : 1);
         int ne = ch ? 2 : 4;
         int nl = ch ? 8 : 16;
         int ox = hl ? (ch ? 2 : 4) : 0;
         int oy = ht ? (ch ? 2 : 4) : 0;
         for (int e = first; e < ne; e++) begin
            for (int l = 0; l < nl; l++) begin
               int er = dir ? oy + e * 4 : oy + l;
               int ec = dir ? ox + l : ox + e * 4;
               int ns = $urandom_range(0, 2);
               int sb;
               int ebs;
               bit head;
               for (int k = 0; k < ns; k++) begin
                  @(negedge clk); filter_ready = 0; seg_bs = 3'($urandom_range(0, 7)); #1;
                  chk("R9 held req", int'(filt_req), 1);
                  chk("R9 held row", int'(filt_row), er);
                  chk("R9 held col", int'(filt_col), ec);
               end
               @(negedge clk); filter_ready = 1; sb = $urandom_range(0, 7); seg_bs = 3'(sb); #1;
               head = !ch && (l % 4 == 0);
               if (head) tbl[dir][e][l/4] = sb;
               ebs = ch ? tbl[dir][2*e][l/2] : tbl[dir][e][l/4];
               chk("R4 req", int'(filt_req), 1);
               chk("R4 plane", int'(filt_plane), pl);
               chk("R4 dir", int'(filt_dir), int'(dir));
               chk("R6 row", int'(filt_row), er);
               chk("R6 col", int'(filt_col), ec);
               if (e == first && l == 0)
                  chk("R5 first edge pos", dir ? int'(filt_row) : int'(filt_col),
                      dir ? oy + first * 4 : ox + first * 4);
               chk("R7 bs_req", int'(bs_req), int'(head));
               if (ch) chk("R8 chroma strength", int'(filt_bs), ebs);
               else    chk("R7 luma strength", int'(filt_bs), ebs);
               @(posedge clk);
            end
         end
      end
      @(negedge clk); filter_ready = 0; #1;
      chk("R10 wb_req", int'(wb_req), 1);
      chk("R10 req over", int'(filt_req), 0);
      for (int k = 0; k < int'($urandom_range(0, 2)); k++) begin
         @(negedge clk); #1;
         chk("R10 wb held", int'(wb_req), 1);
      end
      @(negedge clk); wb_done = 1;
      @(negedge clk); wb_done = 0; #1;
      chk("R10 done", int'(done), 1);
      @(negedge clk); #1;
      chk("R10 done pulse", int'(done), 0);
      chk("R10 idle", int'(fetch_req | filt_req | wb_req), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL R10 watchdog actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7331));
      rst_n = 0; start = 0; fetch_done = 0; filter_ready = 0; wb_done = 0;
      mb_x = '0; mb_y = '0; seg_bs = '0;
      repeat (3) @(negedge clk);
      rst_n = 1; #1;
      chk("R1 fetch_req", int'(fetch_req), 0);
      chk("R1 filt_req", int'(filt_req), 0);
      chk("R1 wb_req", int'(wb_req), 0);
      chk("R1 done", int'(done), 0);
      // R11: out-of-range coordinates
      @(negedge clk); start = 1; mb_x = 5'd22; mb_y = 5'd3;
      @(negedge clk); start = 0; #1;
      chk("R11 column range", int'(fetch_req), 0);
      @(negedge clk); start = 1; mb_x = 5'd4; mb_y = 5'd18;
      @(negedge clk); start = 0; #1;
      chk("R11 row range", int'(fetch_req), 0);
      run_mb(0, 0);
      run_mb(5, 0);
      run_mb(0, 7);
      run_mb(21, 17);
      for (int i = 0; i < 10; i++) run_mb($urandom_range(0, 21), $urandom_range(0, 17));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule